// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Array

This block is one output cell of a small programmable sum-of-products device. Eight product terms arrive from the AND array. The cell ORs them, applies a programmable polarity, and either drives the pin directly or through a D flip-flop clocked by a shared clock. It also picks a tri-state enable for the pin and a feedback value to return to the array. Two global bits are common to every cell and choose the device-wide mode. Two per-cell bits choose this cell's role within that mode and its output polarity.

In registered mode a cell is either a registered output or a combinational I/O. In complex mode every cell is a combinational output whose enable comes from a product term. In simple mode a cell is either an always-enabled combinational output or a dedicated input. When a product term serves as the enable, it is removed from that cell's OR sum. The register has an asynchronous power-on reset and a synchronous preload for test.

Top module: `olm_cell`

## Requirements
- R1: The global bits `cfg_comb_only` and `cfg_arch_sel` choose the mode. With comb_only=0 and arch_sel=1 the mode is registered, and `cfg_io_sel`=0 gives a registered output while `cfg_io_sel`=1 gives a combinational I/O. With comb_only=1 and arch_sel=1 the mode is complex, and `cfg_io_sel` is ignored. Any setting with arch_sel=0 is simple mode.
- R2: `cfg_act_high`=1 drives the logic function true-high on `pin_drive`, and `cfg_act_high`=0 drives it inverted. This holds in every mode and for the register output.
- R3: A registered output captures the OR of all eight terms `pterm[7:0]` on each rising `clk` edge. It drives the polarity-adjusted register value and feeds the register value back on `fb_out`.
- R4: In a combinational I/O and in complex mode, the sum is the OR of `pterm[7:1]` only. `pin_oe` equals `pterm[0]`.
- R5: In a combinational I/O, and in complex mode on an inner cell, `fb_out` equals `pin_in` whether or not the pin is enabled.
- R6: In complex mode an outer cell (parameter `OUTER_CELL`=1) returns `fb_out`=0, whatever the state of `pin_in`.
- R7: In simple mode with `cfg_io_sel`=0, the cell ORs all eight terms, holds `pin_oe`=1 and returns `fb_out`=0. With `cfg_io_sel`=1, `pin_oe`=0, `pin_drive`=0 and `fb_out`=`pin_in`.
- R8: While `rst_n` is low the register holds 0. A registered output then drives `pin_drive` = NOT `cfg_act_high` and returns `fb_out`=0.
- R9: `preload_en`=1 at a rising `clk` edge loads `preload_val` into the register in place of the sum.
- R10: The active-low shared pin `oe_pin_n` sets `pin_oe` = NOT `oe_pin_n` for a registered output only. In every other configuration it has no effect on `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for the register |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_comb_only | input | 1 | Global mode bit: 1 = no registered cells |
| cfg_arch_sel | input | 1 | Global mode bit: 0 = simple mode |
| cfg_io_sel | input | 1 | Per-cell role bit |
| cfg_act_high | input | 1 | Per-cell polarity: 1 = active high |
| pterm | input | 8 | Product terms from the AND array; bit 0 is the enable term |
| oe_pin_n | input | 1 | Shared output-enable pin, active low |
| preload_en | input | 1 | Synchronous register preload strobe |
| preload_val | input | 1 | Value loaded by preload |
| pin_in | input | 1 | Level read back from the external pin |
| pin_drive | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Tri-state enable for the pin |
| fb_out | output | 1 | Feedback value to the AND array |

## Verification
The bench sets `pterm[0]` alone in the eight-term configurations and the seven-term configurations. A cell that drops or keeps the enable term in the wrong mode shows a wrong `pin_drive`. It checks that the shared enable pin is ignored in combinational I/O and complex mode, which catches an enable mux keyed only on the global bits. It drives `pin_in` high on an inner cell and on an outer cell in complex mode, so a feedback that is always on or always off is exposed. Reset and preload are checked at both polarities, which catches a register that stores the inverted value.

// File: rtl/olm_pkg.sv
package olm_pkg;

  typedef enum logic [2:0] {
    K_REG_OUT,
    K_REG_IO,
    K_CPLX_IO,
    K_SIMPLE_OUT,
    K_SIMPLE_IN
  } cell_kind_e;

  typedef enum logic [1:0] {
    OE_FROM_PIN,
    OE_FROM_TERM,
    OE_ALWAYS,
    OE_NEVER
  } oe_src_e;

  typedef enum logic [1:0] {
    FB_FROM_REG,
    FB_FROM_PIN,
    FB_NONE
  } fb_src_e;

  // Mode decode: arch_sel=0 means simple mode regardless of comb_only.
  function automatic cell_kind_e decode_kind(input logic comb_only,
                                             input logic arch_sel,
                                             input logic io_sel);
    cell_kind_e k;
    if (!arch_sel)      k = io_sel ? K_SIMPLE_IN : K_SIMPLE_OUT;
    else if (comb_only) k = K_CPLX_IO;
    else                k = io_sel ? K_REG_IO : K_REG_OUT;
    return k;
  endfunction

  function automatic logic apply_pol(input logic v, input logic act_high);
    return act_high ? v : ~v;
  endfunction

  // True when the enable term is taken out of the OR sum.
  function automatic logic term_is_enable(input cell_kind_e k);
    return (k == K_REG_IO) || (k == K_CPLX_IO);
  endfunction

endpackage

// File: rtl/olm_decode.sv
module olm_decode
  import olm_pkg::*;
#(
  parameter bit OUTER_CELL = 1'b0
) (
  input  logic       comb_only,
  input  logic       arch_sel,
  input  logic       io_sel,
  output cell_kind_e kind,
  output logic       drop_oe_term,
  output oe_src_e    oe_src,
  output fb_src_e    fb_src
);

  fb_src_e fb_cplx;

  generate
    if (OUTER_CELL) begin : g_outer
      assign fb_cplx = FB_NONE;
    end else begin : g_inner
      assign fb_cplx = FB_FROM_PIN;
    end
  endgenerate

  always_comb begin
    kind         = decode_kind(comb_only, arch_sel, io_sel);
    drop_oe_term = term_is_enable(kind);
    unique case (kind)
      K_REG_OUT: begin
        oe_src = OE_FROM_PIN;
        fb_src = FB_FROM_REG;
      end
      K_REG_IO: begin
        oe_src = OE_FROM_TERM;
        fb_src = FB_FROM_PIN;
      end
      K_CPLX_IO: begin
        oe_src = OE_FROM_TERM;
        fb_src = fb_cplx;
      end
      K_SIMPLE_OUT: begin
        oe_src = OE_ALWAYS;
        fb_src = FB_NONE;
      end
      default: begin
        oe_src = OE_NEVER;
        fb_src = FB_FROM_PIN;
      end
    endcase
  end

endmodule

// File: rtl/olm_sum.sv
module olm_sum #(
  parameter int N_TERMS = 8,
  parameter int OE_IDX  = 0
) (
  input  logic [N_TERMS-1:0] terms,
  input  logic               drop_oe,
  output logic               sum
);

  logic [N_TERMS-1:0] masked;

  for (genvar i = 0; i < N_TERMS; i++) begin : g_mask
    if (i == OE_IDX) begin : g_oe
      assign masked[i] = terms[i] & ~drop_oe;
    end else begin : g_plain
      assign masked[i] = terms[i];
    end
  end

  assign sum = |masked;

endmodule

// File: rtl/olm_reg.sv
module olm_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic preload_en,
  input  logic preload_val,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= 1'b0;
    else if (preload_en) q <= preload_val;
    else                 q <= d;
  end

endmodule

// File: rtl/olm_cell.sv
module olm_cell
  import olm_pkg::*;
#(
  parameter int N_TERMS    = 8,
  parameter int OE_IDX     = 0,
  parameter bit OUTER_CELL = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_comb_only,
  input  logic               cfg_arch_sel,
  input  logic               cfg_io_sel,
  input  logic               cfg_act_high,
  input  logic [N_TERMS-1:0] pterm,
  input  logic               oe_pin_n,
  input  logic               preload_en,
  input  logic               preload_val,
  input  logic               pin_in,
  output logic               pin_drive,
  output logic               pin_oe,
  output logic               fb_out
);

  // Named internal events, visible to the bound checker.
  cell_kind_e kind;
  oe_src_e    oe_src;
  fb_src_e    fb_src;
  logic       drop_oe_term;
  logic       sum_raw;
  logic       reg_q;

  olm_decode #(.OUTER_CELL(OUTER_CELL)) u_decode (
    .comb_only    (cfg_comb_only),
    .arch_sel     (cfg_arch_sel),
    .io_sel       (cfg_io_sel),
    .kind         (kind),
    .drop_oe_term (drop_oe_term),
    .oe_src       (oe_src),
    .fb_src       (fb_src)
  );

  olm_sum #(.N_TERMS(N_TERMS), .OE_IDX(OE_IDX)) u_sum (
    .terms   (pterm),
    .drop_oe (drop_oe_term),
    .sum     (sum_raw)
  );

  olm_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .d           (sum_raw),
    .q           (reg_q)
  );

  always_comb begin
    unique case (kind)
      K_REG_OUT:   pin_drive = apply_pol(reg_q, cfg_act_high);
      K_SIMPLE_IN: pin_drive = 1'b0;
      default:     pin_drive = apply_pol(sum_raw, cfg_act_high);
    endcase
  end

  always_comb begin
    unique case (oe_src)
      OE_FROM_PIN:  pin_oe = ~oe_pin_n;
      OE_FROM_TERM: pin_oe = pterm[OE_IDX];
      OE_ALWAYS:    pin_oe = 1'b1;
      default:      pin_oe = 1'b0;
    endcase
  end

  always_comb begin
    unique case (fb_src)
      FB_FROM_REG: fb_out = reg_q;
      FB_FROM_PIN: fb_out = pin_in;
      default:     fb_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/olm_cell_chk.sv
module olm_cell_chk
  import olm_pkg::*;
#(
  parameter int N_TERMS    = 8,
  parameter bit OUTER_CELL = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_io_sel,
  input logic               cfg_act_high,
  input logic [N_TERMS-1:0] pterm,
  input logic               oe_pin_n,
  input logic               preload_en,
  input logic               preload_val,
  input logic               pin_in,
  input logic               pin_drive,
  input logic               pin_oe,
  input logic               fb_out,
  input cell_kind_e         kind,
  input logic               sum_raw,
  input logic               reg_q
);

  assert_regcap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_REG_OUT && !preload_en) |=> (reg_q == $past(sum_raw)));

  assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en |=> (reg_q == $past(preload_val)));

  assert_pin_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_REG_OUT) |-> (pin_oe == !oe_pin_n));

  assert_term_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_REG_IO || kind == K_CPLX_IO) |-> (pin_oe == pterm[0]));

  assert_reg_pol_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_REG_OUT) |-> (pin_drive == (reg_q ~^ cfg_act_high)));

  assert_simple_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SIMPLE_OUT && !cfg_io_sel) |-> (pin_oe && !fb_out));

  assert_pin_fb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_REG_IO) |-> (fb_out == pin_in));

  assert_outer_fb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (OUTER_CELL && kind == K_CPLX_IO) |-> !fb_out);

endmodule

bind olm_cell olm_cell_chk #(.N_TERMS(N_TERMS), .OUTER_CELL(OUTER_CELL)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_io_sel   (cfg_io_sel),
  .cfg_act_high (cfg_act_high),
  .pterm        (pterm),
  .oe_pin_n     (oe_pin_n),
  .preload_en   (preload_en),
  .preload_val  (preload_val),
  .pin_in       (pin_in),
  .pin_drive    (pin_drive),
  .pin_oe       (pin_oe),
  .fb_out       (fb_out),
  .kind         (kind),
  .sum_raw      (sum_raw),
  .reg_q        (reg_q)
);

// File: tb/olm_cell_tb.sv
module olm_cell_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_comb_only = 1'b0;
  logic       cfg_arch_sel = 1'b1;
  logic       cfg_io_sel = 1'b0;
  logic       cfg_act_high = 1'b1;
  logic [7:0] pterm = 8'h00;
  logic       oe_pin_n = 1'b0;
  logic       preload_en = 1'b0;
  logic       preload_val = 1'b0;
  logic       pin_in = 1'b0;
  logic       pin_drive, pin_oe, fb_out;
  logic       o_drive, o_oe, o_fb;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  olm_cell u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_comb_only(cfg_comb_only),
    .cfg_arch_sel(cfg_arch_sel), .cfg_io_sel(cfg_io_sel),
    .cfg_act_high(cfg_act_high), .pterm(pterm), .oe_pin_n(oe_pin_n),
    .preload_en(preload_en), .preload_val(preload_val), .pin_in(pin_in),
    .pin_drive(pin_drive), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  olm_cell #(.OUTER_CELL(1'b1)) u_dut_outer (
    .clk(clk), .rst_n(rst_n), .cfg_comb_only(cfg_comb_only),
    .cfg_arch_sel(cfg_arch_sel), .cfg_io_sel(cfg_io_sel),
    .cfg_act_high(cfg_act_high), .pterm(pterm), .oe_pin_n(oe_pin_n),
    .preload_en(preload_en), .preload_val(preload_val), .pin_in(pin_in),
    .pin_drive(o_drive), .pin_oe(o_oe), .fb_out(o_fb)
  );

  // {comb_only, arch_sel, io_sel, act_high, oe_pin_n, pin_in, pterm[7:0],
  //  exp_drive, exp_oe, exp_fb}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    17'b1_1_1_1_1_0_00000010_1_0_0,  // complex, R4 enable term off
    17'b1_1_1_0_1_1_00000011_0_1_1,  // complex, R2 active low
    17'b1_1_1_1_1_0_00000001_0_1_0,  // complex, R4 term 0 not summed
    17'b1_1_1_0_1_1_00000001_1_1_1,  // complex, R2 inverted zero
    17'b0_1_1_1_0_1_10000000_1_0_1,  // reg-mode I/O, R10 pin ignored
    17'b0_1_1_0_1_0_00000001_1_1_0,  // reg-mode I/O, R4/R5
    17'b1_0_0_1_1_0_00000001_1_1_0,  // simple out, R7 eight terms
    17'b1_0_0_0_1_0_00000000_1_1_0,  // simple out, R2
    17'b1_0_1_1_1_1_11111111_0_0_1,  // simple in, R7
    17'b0_0_0_1_1_0_01000000_1_1_0,  // arch_sel=0 is simple, R1
    17'b1_1_0_1_1_1_00000100_1_0_1,  // complex ignores io_sel, R1
    17'b1_1_1_1_0_0_00000001_0_1_0   // complex, R10 pin ignored
  };

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic cs, input logic as_, input logic io,
                         input logic ah);
    cfg_comb_only = cs;
    cfg_arch_sel  = as_;
    cfg_io_sel    = io;
    cfg_act_high  = ah;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // Reset state: registered output, both polarities (R8, R10)
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1);
    oe_pin_n = 1'b0;
    pterm = 8'hFF;
    @(negedge clk);
    #2;
    chk("R8", "reset drive act-high", pin_drive, 1'b0);
    chk("R8", "reset fb", fb_out, 1'b0);
    chk("R10", "reset oe from pin", pin_oe, 1'b1);
    cfg_act_high = 1'b0;
    #2;
    chk("R8", "reset drive act-low", pin_drive, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // Table of combinational configurations
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_cfg(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13]);
      oe_pin_n = VEC[i][12];
      pin_in   = VEC[i][11];
      pterm    = VEC[i][10:3];
      #2;
      chk("R1/R2/R4", $sformatf("vec %0d drive", i), pin_drive, VEC[i][2]);
      chk("R4/R7/R10", $sformatf("vec %0d oe", i), pin_oe, VEC[i][1]);
      chk("R5/R7", $sformatf("vec %0d fb", i), fb_out, VEC[i][0]);
    end

    // Registered capture of the eight-term sum (R3)
    @(negedge clk);
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1);
    oe_pin_n = 1'b0;
    pterm = 8'h01;
    @(posedge clk);
    #2;
    chk("R3", "capture term0 drive", pin_drive, 1'b1);
    chk("R3", "capture term0 fb", fb_out, 1'b1);
    @(negedge clk);
    pterm = 8'h00;
    #2;
    chk("R3", "holds before edge", pin_drive, 1'b1);
    @(posedge clk);
    #2;
    chk("R3", "capture zero", pin_drive, 1'b0);
    @(negedge clk);
    oe_pin_n = 1'b1;
    #2;
    chk("R10", "shared pin disables", pin_oe, 1'b0);
    cfg_act_high = 1'b0;
    #2;
    chk("R2", "register inverted", pin_drive, 1'b1);

    // Preload overrides the sum (R9)
    @(negedge clk);
    preload_en = 1'b1;
    preload_val = 1'b1;
    pterm = 8'h00;
    @(posedge clk);
    #2;
    chk("R9", "preload 1 fb", fb_out, 1'b1);
    chk("R9", "preload 1 drive act-low", pin_drive, 1'b0);
    @(negedge clk);
    preload_val = 1'b0;
    pterm = 8'hFF;
    @(posedge clk);
    #2;
    chk("R9", "preload 0 over full sum", fb_out, 1'b0);
    @(negedge clk);
    preload_en = 1'b0;

    // Outer cell feedback (R6) versus inner cell (R5)
    @(negedge clk);
    set_cfg(1'b1, 1'b1, 1'b1, 1'b1);
    pin_in = 1'b1;
    pterm = 8'h00;
    #2;
    chk("R6", "outer complex fb", o_fb, 1'b0);
    chk("R5", "inner complex fb disabled pin", fb_out, 1'b1);
    chk("R4", "outer complex oe", o_oe, 1'b0);
    set_cfg(1'b0, 1'b1, 1'b1, 1'b1);
    #2;
    chk("R5", "outer reg-mode I/O fb", o_fb, 1'b1);

    // Reset again mid-run clears the register (R8)
    @(negedge clk);
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1);
    preload_en = 1'b1;
    preload_val = 1'b1;
    @(posedge clk);
    @(negedge clk);
    preload_en = 1'b0;
    rst_n = 1'b0;
    #2;
    chk("R8", "async reset clears q", fb_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule